// File: doc/BRIEF.md
# Programmable Down-Count Interval Timer

This block is a 16-bit count-down timer that sits behind a byte-wide register port. Software writes a 16-bit start value as two bytes, then sets a run bit in an 8-bit control byte. The count then steps down on every system clock cycle, or on each rising edge of an external tick pin when that source is selected. When the count reaches zero, the block records a time-out. It then either stops at zero (single-shot) or reloads itself and goes on producing time-outs at a fixed interval (repeating).

A time-out always sets a sticky flag. The interrupt line shows that flag only while the interrupt enable is set. Reading the control byte clears the flag. The interrupt can also be sent to a general-purpose output, provided the pin is configured as an output. The external tick pin is asynchronous, so it is synchronized and edge-detected before it is used.

Top module: `prog_down_timer`

## Requirements
- R1: After reset, every control bit and both reload bytes are zero, `irq` and `gpio0_out` are low, and reads of addresses 0, 1 and 2 return 0.
- R2: Address 0 is the control byte: bit 0 interrupt enable, bit 1 run, bit 2 single-shot (0 means repeating), bit 3 external tick source, bit 4 route to GPIO. Bits 7:5 always read as 0. Address 1 holds reload bits 7:0 and address 2 holds reload bits 15:8; both read back what was written. Address 3 reads 0. Read data appears on the cycle after the edge that samples `rd_en`.
- R3: When a control write takes run from 0 to 1, the full 16-bit reload value is loaded. With the internal source and reload N (N ≥ 1), the time-out is recorded on the N-th clock edge after that write edge.
- R4: Clearing run holds the count, and no time-out occurs while run is clear. Setting run again reloads the full value and restarts the N-edge interval. A control write that leaves run at 1 does not reload.
- R5: In single-shot mode, exactly one time-out occurs, and the counter then stays at zero until it is restarted.
- R6: In repeating mode, the counter reloads on the edge after it reaches zero, so time-outs fall every N+1 internal clock edges.
- R7: A time-out sets the sticky flag even when the interrupt enable is 0. `irq` equals the flag ANDed with the enable, so setting the enable later raises `irq` right away.
- R8: A read of address 0 clears the flag. If a time-out falls on the same edge as that read, the flag stays set.
- R9: With the external source selected, the counter steps once per rising edge of `tmr_ext_clk` after a two-flop synchronizer. With no edges it does not move, and N edges give a time-out.
- R10: `gpio0_out` equals `irq` when the route bit is 1 and `gpio0_is_out` is 1; otherwise it is 0.
- R11: A reload value of 0 never produces a time-out, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| tmr_ext_clk | input | 1 | Asynchronous external tick pin |
| gpio0_is_out | input | 1 | High when GPIO 0 is configured as an output |
| irq | output | 1 | Time-out interrupt (flag AND enable) |
| gpio0_out | output | 1 | Interrupt copy driven onto GPIO 0 |

## Verification
Two events can land on the same clock edge: a repeating-mode time-out setting the flag, and a control-byte read clearing it. The bench runs the repeating mode with a known interval N and reads the control byte on edge N+1, which must clear the flag. It then places a second read exactly on edge 2N+1, where the next time-out falls. After that read, `irq` must still be high, because the new time-out must not be lost to the clear.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RLD_LO = 2'd1,
    REG_RLD_HI = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // packed: last field is bit 0
  typedef struct packed {
    logic route;
    logic ext_src;
    logic oneshot;
    logic run;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output ctrl_t             ctrl,
  output logic [2*BYTE_W-1:0] reload,
  output logic              start_pulse,
  output logic              ctrl_rd
);
  localparam int PAD_W = BYTE_W - CTRL_W;

  logic [BYTE_W-1:0] rld_lo, rld_hi;
  logic sel_ctrl;

  assign sel_ctrl    = (reg_sel_e'(reg_sel) == REG_CTRL);
  assign start_pulse = wr_en & sel_ctrl & wr_data[1] & ~ctrl.run;
  assign ctrl_rd     = rd_en & sel_ctrl;
  assign reload      = {rld_hi, rld_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      rld_lo <= '0;
      rld_hi <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(reg_sel))
        REG_CTRL:   ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        REG_RLD_LO: rld_lo <= wr_data;
        REG_RLD_HI: rld_hi <= wr_data;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (reg_sel_e'(reg_sel))
        REG_CTRL:   rd_data <= {{PAD_W{1'b0}}, ctrl};
        REG_RLD_LO: rd_data <= rld_lo;
        REG_RLD_HI: rd_data <= rld_hi;
        default:    rd_data <= '0;
      endcase
    end
  end

  // R2: reserved control bits read as zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> rd_data[BYTE_W-1:CTRL_W] == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             oneshot,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic hit, at_zero;

  assign at_zero = (count == '0);
  assign hit     = run & tick & (count == ONE) & ~load;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (load) count <= reload;
    else if (run) begin
      if (at_zero) begin
        if (!oneshot) count <= reload;
      end else if (tick) begin
        count <= count - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R4: paused counter does not move
  assert_pause_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));
  // R5: single-shot stays at zero
  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (oneshot && at_zero && !load) |=> count == '0);
  // R6: repeating mode reloads after zero
  assert_retrig_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !oneshot && at_zero && !load) |=> count == $past(reload));
  // R7: flag sticky until read
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  // R8: time-out wins over same-edge clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (hit && clr) |=> flag);
endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer
  import timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tmr_ext_clk,
  input  logic              gpio0_is_out,
  output logic              irq,
  output logic              gpio0_out
);
  localparam int CNT_W = 2 * BYTE_W;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic start_pulse, ctrl_rd, ext_rise, tick, flag;

  tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .ctrl(ctrl), .reload(reload),
    .start_pulse(start_pulse), .ctrl_rd(ctrl_rd)
  );

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(tmr_ext_clk), .rise(ext_rise)
  );

  assign tick = ctrl.ext_src ? ext_rise : 1'b1;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl.run), .oneshot(ctrl.oneshot),
    .tick(tick), .load(start_pulse), .reload(reload), .clr(ctrl_rd),
    .flag(flag)
  );

  assign irq       = flag & ctrl.irq_en;
  assign gpio0_out = irq & ctrl.route & gpio0_is_out;

  // R10: GPIO copy only when routed and pin is an output
  assert_gpio_route_R10: assert property (@(posedge clk) disable iff (rst)
    gpio0_out |-> (irq && gpio0_is_out));
endmodule

// File: tb/tb_prog_down_timer.sv
module tb_prog_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] C_IE = 8'h01, C_RUN = 8'h02, C_OS = 8'h04,
                         C_EXT = 8'h08, C_RT = 8'h10;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] reg_sel = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tmr_ext_clk = 1'b0, gpio0_is_out = 1'b1;
  logic irq, gpio0_out;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_down_timer dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_ext_clk(tmr_ext_clk),
    .gpio0_is_out(gpio0_is_out), .irq(irq), .gpio0_out(gpio0_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_sel = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_sel = a; rd_en = 1'b1;
    step();
    d = rd_data; rd_en = 1'b0;
  endtask

  task automatic start(input int n, input logic [7:0] c);
    logic [7:0] d;
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    wr(2'd1, n[7:0]);
    wr(2'd2, n[15:8]);
    wr(2'd0, c);
  endtask

  task automatic ext_pulse();
    tmr_ext_clk = 1'b1; steps(3);
    tmr_ext_clk = 1'b0; steps(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    #2;
    steps(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 gpio", gpio0_out, 0);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d); chk("R1 reg", d, 0);
    end

    // R2 register map and reserved bits
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd(2'd1, d); chk("R2 lo", d, 8'hA5);
    rd(2'd2, d); chk("R2 hi", d, 8'h3C);
    rd(2'd3, d); chk("R2 addr3", d, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 ctrl reserved", d, 8'h1F);
    wr(2'd0, 8'h00);

    // R3 / R5: single-shot sweep of interval length
    for (int n = 1; n <= 12; n++) begin
      start(n, C_IE | C_RUN | C_OS);
      if (n > 1) begin steps(n - 1); chk("R3 early", irq, 0); steps(1); end
      else steps(1);
      chk("R3 timeout", irq, 1);
      rd(2'd0, d); chk("R8 cleared", irq, 0);
      steps(3 * n + 2); chk("R5 single", irq, 0);
    end

    // R3 high byte used
    start(258, C_IE | C_RUN | C_OS);
    steps(257); chk("R3 16bit early", irq, 0);
    steps(1);   chk("R3 16bit timeout", irq, 1);

    // R6 repeating interval N+1
    for (int n = 2; n <= 8; n++) begin
      start(n, C_IE | C_RUN);
      steps(n); chk("R6 first", irq, 1);
      rd(2'd0, d); chk("R6 clear", irq, 0);
      steps(n - 1); chk("R6 early", irq, 0);
      steps(1); chk("R6 second", irq, 1);
    end

    // R8 time-out on same edge as clearing read
    for (int n = 2; n <= 6; n++) begin
      start(n, C_IE | C_RUN);
      steps(n);
      rd(2'd0, d); chk("R8 clear", irq, 0);
      steps(n - 1);
      rd(2'd0, d); chk("R8 set wins", irq, 1);
      chk("R8 rd data", d, C_IE | C_RUN);
    end

    // R4 pause, restart reloads, write with run kept does not reload
    start(10, C_IE | C_RUN | C_OS);
    steps(4);
    wr(2'd0, C_IE | C_OS);
    steps(30); chk("R4 paused", irq, 0);
    wr(2'd0, C_IE | C_RUN | C_OS);
    steps(9); chk("R4 restart early", irq, 0);
    steps(1); chk("R4 restart timeout", irq, 1);
    start(10, C_IE | C_RUN | C_OS);
    steps(4);
    wr(2'd0, C_IE | C_RUN | C_OS | C_RT);
    steps(4); chk("R4 no reload early", irq, 0);
    steps(1); chk("R4 no reload timeout", irq, 1);

    // R7 sticky with enable off
    start(3, C_RUN | C_OS);
    steps(10); chk("R7 masked", irq, 0);
    wr(2'd0, C_IE | C_RUN | C_OS);
    chk("R7 sticky", irq, 1);

    // R11 reload zero
    start(0, C_IE | C_RUN | C_OS);
    steps(20); chk("R11 oneshot", irq, 0);
    start(0, C_IE | C_RUN);
    steps(20); chk("R11 repeat", irq, 0);

    // R9 external source
    start(4, C_IE | C_RUN | C_OS | C_EXT);
    steps(20); chk("R9 no edges", irq, 0);
    for (int p = 0; p < 3; p++) ext_pulse();
    steps(4); chk("R9 three edges", irq, 0);
    ext_pulse();
    chk("R9 fourth edge", irq, 1);

    // R10 GPIO routing
    chk("R10 not routed", gpio0_out, 0);
    wr(2'd0, C_IE | C_RUN | C_OS | C_EXT | C_RT);
    gpio0_is_out = 1'b1; #1; chk("R10 routed", gpio0_out, 1);
    gpio0_is_out = 1'b0; #1; chk("R10 input pin", gpio0_out, 0);
    gpio0_is_out = 1'b1;
    wr(2'd0, C_RUN | C_OS | C_EXT | C_RT);
    chk("R10 irq disabled", gpio0_out, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule